// File: doc/BRIEF.md
# DMA Interrupt Coalescing Register Block

This block is the control and status register file for a two-channel scatter-gather DMA engine. Software reads and writes 32-bit registers through a simple strobe port. Each channel has a 0x30-byte window holding a control word, a status word, a current descriptor pointer and a tail descriptor pointer. Writing a channel's tail pointer sends a one-cycle start pulse toward the datapath, which fetches descriptors and moves data outside this block.

The datapath reports the end of each frame with a one-cycle completion pulse per channel. The block holds interrupt moderation state for each channel. A completion counter raises a completion flag once a programmed number of frames has finished. A delay timer is re-armed by every completion and raises a delay flag if no further frame completes before it runs out. Each flag drives its channel's interrupt line only when the matching enable bit in the control word is set. Software clears a flag by writing 1 to its status bit. The live counter value and the live timer value can be read back in the upper bytes of the status word.

Top module: `dma_irq_coalesce_regs`

## Requirements
- R1: The channel is selected by (address / 0x30) modulo 2, and the register by address modulo 0x30. The offsets are 0x00 control, 0x04 status, 0x08 current descriptor and 0x10 tail descriptor. Any other offset reads as 0. Read data appears on `bus_rdata` one cycle after the `bus_rd` strobe.
- R2: Control bit 1 (tail-pointer mode) always reads as 1, whatever value was written to it.
- R3: After `rst`, control reads 0x0001_0002 (threshold 1 in bits 23:16) and status reads 0x0001_0001 (halted in bit 0, count 1 in bits 23:16). All irq and start outputs are low.
- R4: A control write with run (bit 0) set clears the halted (bit 0) and idle (bit 1) status bits, unless the stored soft-reset bit is set after the write.
- R5: Writing 1 to status bits 14:12 clears the matching flags. Bit 12 is the completion flag and bit 13 is the delay flag. Writing 0 to a flag bit leaves it unchanged.
- R6: `irq[c]` is high exactly when some status bit in 14:12 and the control bit at the same position are both set.
- R7: Each completion pulse decrements the counter. When the counter is 1 or 0 before the pulse, the pulse sets the completion flag and reloads the counter from control bits 23:16. Every control write reloads the counter from the newly written threshold.
- R8: A completion with control bits 31:24 = D, where D is nonzero, loads the timer with D. The timer then counts down once every PRESCALE cycles. The delay flag is set D*PRESCALE clock edges after the completion edge. If D is 0, the timer is not touched.
- R9: When the timer expires, the completion counter is reloaded from the threshold.
- R10: A completion that arrives while the timer is running restarts the timer from D.
- R11: A status read returns {timer[7:0], count[7:0], 1'b0, flags[2:0], 10'b0, idle, halted}.
- R12: A control write with bit 2 set performs a soft reset. It restores the R3 values, clears the flags and the timer, and latches bit 2. Bit 2 stays set across later control writes and blocks run. It reads back as 1 exactly once: the control read clears it.
- R13: A tail-pointer write stores the pointer and clears idle. It also drives that channel's `start_pulse` high for exactly the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| frame_done | input | NUM_CH (2) | One-cycle completion pulse per channel |
| irq | output | NUM_CH (2) | Interrupt line per channel |
| start_pulse | output | NUM_CH (2) | One-cycle start request per channel |

## Verification
Register writes, W1C clears and completion pulses take effect at the clock edge that samples them. The bench therefore checks flags, halted state and the combinational `irq` at the falling edge right after that edge. `start_pulse` is registered: it is checked high at that same falling edge and low one cycle later. Read data is registered, so every read samples `bus_rdata` at the falling edge after the capturing edge. The delay flag is due exactly D*PRESCALE edges after the completion edge. The bench counts edges from the completion and checks the interrupt low one cycle before that edge and high right after it, both for a single completion and for a restart in mid-countdown.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int unsigned DW = 32;

    localparam int unsigned CTRL_RUN      = 0;
    localparam int unsigned CTRL_TAILMODE = 1;
    localparam int unsigned CTRL_SRST     = 2;

    localparam logic [DW-1:0] CTRL_RST_VAL = 32'h0001_0002;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_CUR,
        SEL_TAIL
    } reg_sel_e;

    typedef struct packed {
        logic          wr;
        logic          rd;
        reg_sel_e      sel;
        logic [DW-1:0] wdata;
    } chan_req_t;

    typedef struct packed {
        logic [7:0] tmr;
        logic [7:0] cnt;
        logic [2:0] flags;
        logic       idle;
        logic       halted;
    } chan_stat_t;

    // Offset within a channel window to register select (R1)
    function automatic reg_sel_e decode_off(input int unsigned off);
        case (off)
            32'h00:  return SEL_CTRL;
            32'h04:  return SEL_STAT;
            32'h08:  return SEL_CUR;
            32'h10:  return SEL_TAIL;
            default: return SEL_NONE;
        endcase
    endfunction

    // Status word layout (R11)
    function automatic logic [DW-1:0] pack_status(input chan_stat_t s);
        return {s.tmr, s.cnt, 1'b0, s.flags, 10'b0, s.idle, s.halted};
    endfunction

endpackage

// File: rtl/dmac_coal_cnt.sv
module dmac_coal_cnt (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] load_val,
    input  logic       frame,
    input  logic       expire,
    input  logic [7:0] thresh,
    output logic [7:0] cnt_o,
    output logic       fire_o
);
    logic [7:0] cnt_q;

    // Counter at 1 or 0 means this completion reaches the threshold
    assign fire_o = frame && (cnt_q <= 8'd1);
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= 8'd1;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (frame) begin
            if (cnt_q <= 8'd1) cnt_q <= thresh;
            else               cnt_q <= cnt_q - 8'd1;
        end else if (expire) begin
            cnt_q <= thresh;
        end
    end

    p_dec_r7: assert property (@(posedge clk) disable iff (rst)
        frame && !load && (cnt_q > 8'd1) |=> cnt_q == $past(cnt_q) - 8'd1);

    p_reload_r7: assert property (@(posedge clk) disable iff (rst)
        frame && !load && (cnt_q <= 8'd1) |=> cnt_q == $past(thresh));

    p_expire_reload_r9: assert property (@(posedge clk) disable iff (rst)
        expire && !frame && !load |=> cnt_q == $past(thresh));

endmodule

// File: rtl/dmac_dly_tmr.sv
module dmac_dly_tmr #(
    parameter int unsigned PRESCALE = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       start,
    input  logic [7:0] start_val,
    output logic [7:0] tmr_o,
    output logic       expire_o
);
    localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic [7:0] tmr_q;
    logic       tick;

    generate
        if (PRESCALE > 1) begin : g_pre
            localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(PRESCALE - 1);
            logic [PRE_W-1:0] pre_q;
            always_ff @(posedge clk) begin
                if (rst || clear || start || (tmr_q == 8'd0)) pre_q <= '0;
                else if (pre_q == PRE_TOP)                   pre_q <= '0;
                else                                         pre_q <= pre_q + 1'b1;
            end
            assign tick = (pre_q == PRE_TOP) && (tmr_q != 8'd0);
        end else begin : g_nopre
            assign tick = (tmr_q != 8'd0);
        end
    endgenerate

    assign expire_o = tick && (tmr_q == 8'd1) && !start && !clear;
    assign tmr_o    = tmr_q;

    always_ff @(posedge clk) begin
        if (rst || clear)  tmr_q <= 8'd0;
        else if (start)    tmr_q <= start_val;
        else if (tick)     tmr_q <= tmr_q - 8'd1;
    end

    p_load_r10: assert property (@(posedge clk) disable iff (rst)
        start && !clear |=> tmr_q == $past(start_val));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !start && !clear && !tick |=> $stable(tmr_q));

endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
    import dmac_pkg::*;
#(
    parameter int unsigned PRESCALE = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  chan_req_t     req,
    input  logic          frame_done,
    output logic [DW-1:0] rdata_o,
    output logic          irq_o,
    output logic          start_o
);
    logic [DW-1:0] ctrl_q, cur_q, tail_q;
    logic          halted_q, idle_q, start_q;
    logic [2:0]    flags_q;

    logic ctrl_wr, ctrl_rd, stat_wr, cur_wr, tail_wr, srst_req;
    logic [DW-1:0] ctrl_merge;
    logic [7:0] cnt, tmr, cnt_load_val;
    logic fire, expire, tmr_start;
    logic [2:0] flag_set, flag_clr;
    chan_stat_t stat;

    assign ctrl_wr = req.wr && (req.sel == SEL_CTRL);
    assign ctrl_rd = req.rd && (req.sel == SEL_CTRL);
    assign stat_wr = req.wr && (req.sel == SEL_STAT);
    assign cur_wr  = req.wr && (req.sel == SEL_CUR);
    assign tail_wr = req.wr && (req.sel == SEL_TAIL);

    // Tail mode forced on, pending soft reset kept (R2, R12)
    assign ctrl_merge = req.wdata | (DW'(1) << CTRL_TAILMODE)
                      | ({{(DW-1){1'b0}}, ctrl_q[CTRL_SRST]} << CTRL_SRST);
    assign srst_req   = ctrl_wr && req.wdata[CTRL_SRST];
    assign cnt_load_val = srst_req ? CTRL_RST_VAL[23:16] : ctrl_merge[23:16];
    assign tmr_start  = frame_done && (ctrl_q[31:24] != 8'd0);

    dmac_coal_cnt u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (ctrl_wr),
        .load_val (cnt_load_val),
        .frame    (frame_done),
        .expire   (expire),
        .thresh   (ctrl_q[23:16]),
        .cnt_o    (cnt),
        .fire_o   (fire)
    );

    dmac_dly_tmr #(.PRESCALE(PRESCALE)) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .clear     (srst_req),
        .start     (tmr_start),
        .start_val (ctrl_q[31:24]),
        .tmr_o     (tmr),
        .expire_o  (expire)
    );

    assign flag_set = {1'b0, expire, fire};
    assign flag_clr = stat_wr ? req.wdata[14:12] : 3'b000;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= CTRL_RST_VAL;
            cur_q    <= '0;
            tail_q   <= '0;
            halted_q <= 1'b1;
            idle_q   <= 1'b0;
            flags_q  <= 3'b000;
            start_q  <= 1'b0;
        end else begin
            start_q <= tail_wr;
            flags_q <= (flags_q & ~flag_clr) | flag_set;
            if (ctrl_wr) begin
                if (srst_req) begin
                    ctrl_q   <= CTRL_RST_VAL | (DW'(1) << CTRL_SRST);
                    halted_q <= 1'b1;
                    idle_q   <= 1'b0;
                    flags_q  <= 3'b000;
                end else begin
                    ctrl_q <= ctrl_merge;
                    if (ctrl_merge[CTRL_RUN] && !ctrl_merge[CTRL_SRST]) begin
                        halted_q <= 1'b0;
                        idle_q   <= 1'b0;
                    end
                end
            end else if (ctrl_rd) begin
                ctrl_q[CTRL_SRST] <= 1'b0;
            end
            if (cur_wr) cur_q <= req.wdata;
            if (tail_wr) begin
                tail_q <= req.wdata;
                idle_q <= 1'b0;
            end
        end
    end

    assign stat = '{tmr: tmr, cnt: cnt, flags: flags_q, idle: idle_q, halted: halted_q};

    always_comb begin
        case (req.sel)
            SEL_CTRL: rdata_o = ctrl_q;
            SEL_STAT: rdata_o = pack_status(stat);
            SEL_CUR:  rdata_o = cur_q;
            SEL_TAIL: rdata_o = tail_q;
            default:  rdata_o = '0;
        endcase
    end

    assign irq_o   = |(flags_q & ctrl_q[14:12]);
    assign start_o = start_q;

    p_w1c_ioc_r5: assert property (@(posedge clk) disable iff (rst)
        stat_wr && req.wdata[12] && !fire |=> !flags_q[0]);

    p_w1c_dly_r5: assert property (@(posedge clk) disable iff (rst)
        stat_wr && req.wdata[13] && !expire |=> !flags_q[1]);

    p_run_r4: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr && req.wdata[CTRL_RUN] && !req.wdata[CTRL_SRST] && !ctrl_q[CTRL_SRST]
        |=> !halted_q);

    p_srst_r12: assert property (@(posedge clk) disable iff (rst)
        srst_req |=> halted_q && ctrl_q[CTRL_SRST] && (flags_q == 3'b000));

    p_srst_blocks_run_r12: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr && ctrl_q[CTRL_SRST] && halted_q |=> halted_q);

    p_start_r13: assert property (@(posedge clk) disable iff (rst)
        tail_wr |=> start_o);

    p_start_once_r13: assert property (@(posedge clk) disable iff (rst)
        !tail_wr |=> !start_o);

    p_irq_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (flags_q == 3'b000) |-> !irq_o);

endmodule

// File: rtl/dma_irq_coalesce_regs.sv
module dma_irq_coalesce_regs
    import dmac_pkg::*;
#(
    parameter int unsigned NUM_CH   = 2,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned STRIDE   = 48,
    parameter int unsigned PRESCALE = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NUM_CH-1:0] frame_done,
    output logic [NUM_CH-1:0] irq,
    output logic [NUM_CH-1:0] start_pulse
);
    int unsigned ch_idx;
    int unsigned off;
    reg_sel_e    sel;
    logic [DW-1:0] ch_rdata [NUM_CH];
    logic [DW-1:0] rd_mux;
    logic [DW-1:0] rdata_q;

    // Channel and register decode (R1)
    always_comb begin
        ch_idx = (int'(bus_addr) / STRIDE) % NUM_CH;
        off    = int'(bus_addr) % STRIDE;
        sel    = decode_off(off);
    end

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            chan_req_t req_c;
            assign req_c.wr    = bus_wr && (ch_idx == c);
            assign req_c.rd    = bus_rd && (ch_idx == c);
            assign req_c.sel   = sel;
            assign req_c.wdata = bus_wdata;

            dmac_chan_regs #(.PRESCALE(PRESCALE)) u_chan (
                .clk        (clk),
                .rst        (rst),
                .req        (req_c),
                .frame_done (frame_done[c]),
                .rdata_o    (ch_rdata[c]),
                .irq_o      (irq[c]),
                .start_o    (start_pulse[c])
            );
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_idx == c) rd_mux = ch_rdata[c];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;

    p_tailmode_r2: assert property (@(posedge clk) disable iff (rst)
        bus_rd && (sel == SEL_CTRL) |=> bus_rdata[CTRL_TAILMODE]);

    p_unmapped_r1: assert property (@(posedge clk) disable iff (rst)
        bus_rd && (sel == SEL_NONE) |=> bus_rdata == '0);

endmodule

// File: tb/sim_dma_irq_coalesce_regs.sv
module sim_dma_irq_coalesce_regs;
    localparam int PRE = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  frame_done = '0;
    logic [1:0]  irq, start_pulse;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dma_irq_coalesce_regs #(.PRESCALE(PRE)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .frame_done(frame_done), .irq(irq), .start_pulse(start_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [1:0] m);
        @(negedge clk);
        frame_done = m;
        @(negedge clk);
        frame_done = 2'b00;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(8'h00, v); chk("R3 ctrl reset", v, 32'h0001_0002);
        rd(8'h04, v); chk("R3 status reset", v, 32'h0001_0001);
        rd(8'h30, v); chk("R3 ch1 ctrl reset", v, 32'h0001_0002);
        chk("R3 irq/start low", {30'b0, irq | start_pulse}, 32'h0);
    endtask

    task automatic t_tailmode;
        logic [31:0] v;
        wr(8'h00, 32'h0000_0000);
        rd(8'h00, v); chk("R2 tail mode forced", v, 32'h0000_0002);
        rd(8'h04, v); chk("R4 no run stays halted", v & 32'h1, 32'h1);
    endtask

    task automatic t_threshold;
        logic [31:0] v;
        wr(8'h00, 32'h0003_1001);
        rd(8'h04, v); chk("R4 run clears halted", v, 32'h0003_0000);
        pulse(2'b01); pulse(2'b01);
        rd(8'h04, v); chk("R7 count after two", v, 32'h0001_0000);
        chk("R6 irq low before threshold", {30'b0, irq}, 32'h0);
        pulse(2'b01);
        chk("R7 irq at threshold", {30'b0, irq}, 32'h1);
        rd(8'h04, v); chk("R7 flag set, count reloaded", v, 32'h0003_1000);
        wr(8'h04, 32'h0000_1000);
        chk("R5 W1C drops irq", {30'b0, irq}, 32'h0);
        rd(8'h04, v); chk("R5 flag cleared", v, 32'h0003_0000);
    endtask

    task automatic t_enable;
        logic [31:0] v;
        wr(8'h00, 32'h0001_0001);
        pulse(2'b01);
        rd(8'h04, v); chk("R6 flag set while disabled", v, 32'h0001_1000);
        chk("R6 irq masked", {30'b0, irq}, 32'h0);
        wr(8'h04, 32'h0000_0000);
        rd(8'h04, v); chk("R5 zero write keeps flag", v, 32'h0001_1000);
        wr(8'h04, 32'h0000_7000);
        rd(8'h04, v); chk("R5 flags cleared", v, 32'h0001_0000);
    endtask

    task automatic t_delay;
        logic [31:0] v;
        wr(8'h00, 32'h0405_2001);
        pulse(2'b01);
        rd(8'h04, v); chk("R11 live timer and count", v, 32'h0404_0000);
        repeat (13) @(posedge clk);
        @(negedge clk); chk("R8 irq low one edge early", {30'b0, irq}, 32'h0);
        @(posedge clk);
        @(negedge clk); chk("R8 delay irq on time", {30'b0, irq}, 32'h1);
        rd(8'h04, v); chk("R9 count reloaded on expiry", v, 32'h0005_2000);
        wr(8'h04, 32'h0000_2000);
    endtask

    task automatic t_restart;
        logic [31:0] v;
        pulse(2'b01);
        repeat (8) @(posedge clk);
        pulse(2'b01);
        repeat (15) @(posedge clk);
        @(negedge clk); chk("R10 restarted, not yet expired", {30'b0, irq}, 32'h0);
        @(posedge clk);
        @(negedge clk); chk("R10 expiry after restart", {30'b0, irq}, 32'h1);
        rd(8'h04, v); chk("R10 status after restart", v, 32'h0005_2000);
        wr(8'h04, 32'h0000_2000);
        wr(8'h00, 32'h0005_2001);
        pulse(2'b01);
        repeat (40) @(posedge clk);
        @(negedge clk); chk("R8 zero delay no timer", {30'b0, irq}, 32'h0);
        rd(8'h04, v); chk("R8 zero delay status", v, 32'h0004_0000);
    endtask

    task automatic t_softreset;
        logic [31:0] v;
        wr(8'h00, 32'h0000_0005);
        rd(8'h04, v); chk("R12 status after soft reset", v, 32'h0001_0001);
        wr(8'h00, 32'h0000_0001);
        rd(8'h04, v); chk("R12 run blocked while reset pending", v, 32'h0000_0001);
        rd(8'h00, v); chk("R12 reset bit read once", v, 32'h0000_0007);
        rd(8'h00, v); chk("R12 reset bit cleared by read", v, 32'h0000_0003);
        wr(8'h00, 32'h0000_0001);
        rd(8'h04, v); chk("R4 run after reset cleared", v, 32'h0000_0000);
    endtask

    task automatic t_map_tail;
        logic [31:0] v;
        wr(8'h38, 32'hA5A5_0000);
        wr(8'h08, 32'h1111_0040);
        rd(8'h38, v); chk("R1 ch1 current desc", v, 32'hA5A5_0000);
        rd(8'h08, v); chk("R1 ch0 current desc", v, 32'h1111_0040);
        rd(8'h0C, v); chk("R1 unmapped offset", v, 32'h0);
        wr(8'h10, 32'h1234_5670);
        chk("R13 ch0 start pulse", {30'b0, start_pulse}, 32'h1);
        @(negedge clk); chk("R13 start one cycle", {30'b0, start_pulse}, 32'h0);
        wr(8'h40, 32'h0000_0F00);
        chk("R13 ch1 start pulse", {30'b0, start_pulse}, 32'h2);
        rd(8'h40, v); chk("R13 ch1 tail readback", v, 32'h0000_0F00);
        rd(8'h10, v); chk("R13 ch0 tail readback", v, 32'h1234_5670);
        wr(8'h30, 32'h0001_1001);
        pulse(2'b10);
        chk("R1 ch1 irq only", {30'b0, irq}, 32'h2);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_tailmode();
        t_threshold();
        t_enable();
        t_delay();
        t_restart();
        t_softreset();
        t_map_tail();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule